// File: doc/BRIEF.md
# Word-Serial P-256 Modular Multiplier

This block multiplies two 256-bit values and returns the product reduced modulo the NIST P-256 prime. The operands are never presented as wide buses: the block drives word indices to three external synchronous memories holding X, Y and the modulus N, and takes back one 32-bit word per index a clock later. A single 32x32 multiplier forms every partial product. The partial products are summed into a 512-bit accumulator at their column offsets.

Once the full product is built, a fold stage exploits the special form of the prime. It splits the sixteen product words into nine 256-bit terms, which are added and subtracted in one step. A short correction loop then adds or subtracts the fetched modulus one step per cycle until the value lies in [0, N). The result is streamed out as eight words into an external result memory, least significant word first. A requester pulses the start input for one cycle and polls the ready output.

The controller has five states:
- IDLE: ready is high. A start pulse clears the accumulator and moves to MUL.
- MUL: issues 64 operand index pairs and drains the last product. It moves to FOLD when the issue counter reaches 64.
- FOLD: registers the fold sum and moves to CORR.
- CORR: takes one modulus add or subtract per cycle. It moves to WRITE once the value is in range.
- WRITE: emits one word per cycle and returns to IDLE after word 7.

Top module: `p256_modmul`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rdy` is 1 and `p_wren` is 0.
- R2: A one-cycle `ena` pulse sampled while `rdy` is 1 makes `rdy` read 0 in the following cycle.
- R3: Each operand is eight 32-bit words at word indices 0 to 7, with index 0 holding bits 31:0. Read data is taken one clock after the index is driven on `x_addr`, `y_addr` or `n_addr`.
- R4: With X < N, Y < N and N equal to the P-256 prime, the eight written words together equal (X*Y) mod N. This covers the corner operands X=0, X=1 and X=Y=N-1.
- R5: The result is written over eight consecutive cycles with `p_wren` high, at `p_addr` 0,1,...,7 in that order. Word k carries bits 32k+31:32k. `p_wren` is never high while `rdy` is 1.
- R6: `rdy` returns to 1 in the cycle right after word 7 is written. By then all eight words are in the result memory.
- R7: `ena` pulses while `rdy` is 0 are ignored. The operation neither restarts nor lengthens, and its result is unchanged.
- R8: From the enable edge, `rdy` stays 0 for at most 80 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ena | input | 1 | One-cycle start pulse |
| rdy | output | 1 | High when idle and the last result is complete |
| x_addr | output | 3 | Word index into the X memory |
| y_addr | output | 3 | Word index into the Y memory |
| n_addr | output | 3 | Word index into the modulus memory |
| p_addr | output | 3 | Word index into the result memory |
| p_wren | output | 1 | Result memory write strobe |
| x_din | input | 32 | X word, one clock after `x_addr` |
| y_din | input | 32 | Y word, one clock after `y_addr` |
| n_din | input | 32 | Modulus word, one clock after `n_addr` |
| p_dout | output | 32 | Result word for `p_addr` |

## Verification
The bench builds the block with its package defaults: 32-bit words, eight words per operand and a 3-bit index. At these values the product spans the full sixteen-word column range, which lets random operands carry into every accumulator word and drive the fold to both its negative and its above-N extremes. The corner cases X=Y=N-1, X=1 and X=0 are included, as is a busy-time start pulse. These exercise the correction loop, the straight-through path and the all-zero path, and cover the full span of write indices.

// File: rtl/p256_mm_pkg.sv
package p256_mm_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 8;
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam int OP_W      = WORD_W * NUM_WORDS;
    localparam int PROD_W    = 2 * OP_W;
    localparam int SUM_W     = OP_W + 8;
    localparam int PAIRS     = NUM_WORDS * NUM_WORDS;
    localparam int CNT_W     = $clog2(PAIRS) + 1;
    localparam int COL_W     = IDX_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL,
        ST_FOLD,
        ST_CORR,
        ST_WRITE
    } mm_state_e;

    function automatic logic signed [SUM_W-1:0] widen(input logic [OP_W-1:0] v);
        return $signed({8'b0, v});
    endfunction
endpackage

// File: rtl/p256_mac.sv
module p256_mac
    import p256_mm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              vld,
    input  logic [COL_W-1:0]  col,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [PROD_W-1:0] acc
);
    logic [2*WORD_W-1:0] prod;
    logic [PROD_W-1:0]   addend;

    assign prod   = {{WORD_W{1'b0}}, a} * {{WORD_W{1'b0}}, b};
    assign addend = {{(PROD_W-2*WORD_W){1'b0}}, prod} << (col * WORD_W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc <= '0;
        else if (clr) acc <= '0;
        else if (vld) acc <= acc + addend;
    end
endmodule

// File: rtl/p256_fold.sv
module p256_fold
    import p256_mm_pkg::*;
(
    input  logic [PROD_W-1:0]       prod,
    output logic signed [SUM_W-1:0] sum
);
    localparam logic [WORD_W-1:0] Z = '0;
    logic [WORD_W-1:0] c [2*NUM_WORDS];
    logic [OP_W-1:0] t, s1, s2, s3, s4, d1, d2, d3, d4;

    for (genvar k = 0; k < 2*NUM_WORDS; k++) begin : g_split
        assign c[k] = prod[k*WORD_W +: WORD_W];
    end

    always_comb begin
        // terms listed most significant word first
        t  = prod[OP_W-1:0];
        s1 = {c[15], c[14], c[13], c[12], c[11], Z,     Z,     Z    };
        s2 = {Z,     c[15], c[14], c[13], c[12], Z,     Z,     Z    };
        s3 = {c[15], c[14], Z,     Z,     Z,     c[10], c[9],  c[8] };
        s4 = {c[8],  c[13], c[15], c[14], c[13], c[11], c[10], c[9] };
        d1 = {c[10], c[8],  Z,     Z,     Z,     c[13], c[12], c[11]};
        d2 = {c[11], c[9],  Z,     Z,     c[15], c[14], c[13], c[12]};
        d3 = {c[12], Z,     c[10], c[9],  c[8],  c[15], c[14], c[13]};
        d4 = {c[13], Z,     c[11], c[10], c[9],  Z,     c[15], c[14]};
        sum = widen(t) + widen(s1) + widen(s1) + widen(s2) + widen(s2)
            + widen(s3) + widen(s4)
            - widen(d1) - widen(d2) - widen(d3) - widen(d4);
    end
endmodule

// File: rtl/p256_modmul.sv
module p256_modmul
    import p256_mm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ena,
    output logic              rdy,
    output logic [IDX_W-1:0]  x_addr,
    output logic [IDX_W-1:0]  y_addr,
    output logic [IDX_W-1:0]  n_addr,
    output logic [IDX_W-1:0]  p_addr,
    output logic              p_wren,
    input  logic [WORD_W-1:0] x_din,
    input  logic [WORD_W-1:0] y_din,
    input  logic [WORD_W-1:0] n_din,
    output logic [WORD_W-1:0] p_dout
);
    mm_state_e              state, state_nx;
    logic [CNT_W-1:0]       cnt;
    logic [CNT_W-2:0]       idx_q;
    logic                   vld_q;
    logic [IDX_W-1:0]       wcnt;
    logic [OP_W-1:0]        nreg;
    logic signed [SUM_W-1:0] rsum, fsum;
    logic [PROD_W-1:0]      acc;
    logic                   start, issue, in_range;
    logic [COL_W-1:0]       col;

    assign start    = (state == ST_IDLE) && ena;
    assign issue    = (state == ST_MUL) && !cnt[CNT_W-1];
    assign col      = COL_W'(idx_q[CNT_W-2:IDX_W]) + COL_W'(idx_q[IDX_W-1:0]);
    assign in_range = !rsum[SUM_W-1] && (rsum < widen(nreg));

    p256_mac u_mac (
        .clk(clk), .rst_n(rst_n), .clr(start), .vld(vld_q),
        .col(col), .a(x_din), .b(y_din), .acc(acc)
    );

    p256_fold u_fold (.prod(acc), .sum(fsum));

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (ena) state_nx = ST_MUL;
            ST_MUL:   if (cnt[CNT_W-1]) state_nx = ST_FOLD;
            ST_FOLD:  state_nx = ST_CORR;
            ST_CORR:  if (in_range) state_nx = ST_WRITE;
            ST_WRITE: if (wcnt == IDX_W'(NUM_WORDS-1)) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        rdy    = (state == ST_IDLE);
        p_wren = (state == ST_WRITE);
        x_addr = cnt[CNT_W-2:IDX_W];
        y_addr = cnt[IDX_W-1:0];
        n_addr = cnt[IDX_W-1:0];
        p_addr = wcnt;
        p_dout = rsum[wcnt*WORD_W +: WORD_W];
    end

    // sequencing and reduction datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            idx_q <= '0;
            vld_q <= 1'b0;
            wcnt  <= '0;
            nreg  <= '0;
            rsum  <= '0;
        end else begin
            vld_q <= issue;
            idx_q <= cnt[CNT_W-2:0];
            if (start)      cnt <= '0;
            else if (issue) cnt <= cnt + 1'b1;
            if (vld_q && idx_q[CNT_W-2:IDX_W] == '0)
                nreg[idx_q[IDX_W-1:0]*WORD_W +: WORD_W] <= n_din;
            if (state == ST_FOLD) rsum <= fsum;
            else if (state == ST_CORR && !in_range) begin
                if (rsum[SUM_W-1]) rsum <= rsum + widen(nreg);
                else               rsum <= rsum - widen(nreg);
            end
            if (start)                  wcnt <= '0;
            else if (state == ST_WRITE) wcnt <= wcnt + 1'b1;
        end
    end
endmodule

// File: rtl/p256_modmul_chk.sv
module p256_modmul_chk
    import p256_mm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ena,
    input logic             rdy,
    input logic             p_wren,
    input logic [IDX_W-1:0] p_addr
);
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R1: assert (rdy && !p_wren);
        end
    end

    assert_rdy_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && ena) |=> !rdy);

    assert_no_write_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        p_wren |-> !rdy);

    assert_first_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_wren) |-> (p_addr == '0));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (p_wren && p_addr != IDX_W'(NUM_WORDS-1)) |=>
            (p_wren && p_addr == $past(p_addr) + IDX_W'(1)));

    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> ($past(p_wren) && $past(p_addr) == IDX_W'(NUM_WORDS-1)));

    assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && !p_wren) |=> !rdy);
endmodule

bind p256_modmul p256_modmul_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ena(ena), .rdy(rdy),
    .p_wren(p_wren), .p_addr(p_addr)
);

// File: tb/p256_modmul_tb_top.sv
module p256_modmul_tb_top;
    localparam logic [255:0] PRIME =
        256'hffffffff00000001000000000000000000000000ffffffffffffffffffffffff;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, ena, rdy, p_wren;
    logic [2:0]  x_addr, y_addr, n_addr, p_addr;
    logic [31:0] x_din, y_din, n_din, p_dout;

    logic [31:0] xm [8];
    logic [31:0] ym [8];
    logic [31:0] nm [8];
    logic [31:0] pm [8];

    int vectors = 0;
    int fails   = 0;
    int wtotal  = 0;
    int wbase   = 0;
    int cyc     = 0;
    logic [255:0] exp_res = '0;

    p256_modmul dut_i (
        .clk(clk), .rst_n(rst_n), .ena(ena), .rdy(rdy),
        .x_addr(x_addr), .y_addr(y_addr), .n_addr(n_addr),
        .p_addr(p_addr), .p_wren(p_wren),
        .x_din(x_din), .y_din(y_din), .n_din(n_din), .p_dout(p_dout)
    );

    // synchronous read-first memories
    always @(posedge clk) begin
        x_din <= xm[x_addr];
        y_din <= ym[y_addr];
        n_din <= nm[n_addr];
        if (p_wren) pm[p_addr] <= p_dout;
    end

    task automatic check(input string req, input logic [255:0] act,
                         input logic [255:0] expv);
        vectors++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // per-clock comparison of the write stream against the model
    always @(negedge clk) begin
        if (rst_n && p_wren) begin
            check("R5 busy during write", 256'(rdy), 256'(0));
            check("R5 write index", 256'(p_addr), 256'(wtotal - wbase));
            check("R4 written word", 256'(p_dout),
                  256'(exp_res[(wtotal - wbase) % 8 * 32 +: 32]));
            wtotal++;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    function automatic logic [255:0] rnd_reduced();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        return v % PRIME;
    endfunction

    task automatic run_op(input logic [255:0] x, input logic [255:0] y,
                          input bit busy_pulse);
        int lowc;
        logic [511:0] full;
        logic [255:0] got;
        for (int k = 0; k < 8; k++) begin
            xm[k] = x[k*32 +: 32];
            ym[k] = y[k*32 +: 32];
            nm[k] = PRIME[k*32 +: 32];
            pm[k] = 32'hdeadbeef;
        end
        full    = {256'b0, x} * {256'b0, y};
        full    = full % {256'b0, PRIME};
        exp_res = full[255:0];
        wbase   = wtotal;
        @(negedge clk);
        ena = 1'b1;
        @(negedge clk);
        ena = 1'b0;
        check("R2 rdy drops", 256'(rdy), 256'(0));
        lowc = 1;
        while (!rdy && lowc < 1000) begin
            @(negedge clk);
            if (!rdy) lowc++;
            // R7: start pulse while busy
            if (busy_pulse && lowc == 10) ena = 1'b1;
            if (busy_pulse && lowc == 11) ena = 1'b0;
        end
        ena = 1'b0;
        check("R8 busy length bound", 256'(lowc <= 80), 256'(1));
        check("R6 all words written at ready", 256'(wtotal - wbase), 256'(8));
        for (int k = 0; k < 8; k++) got[k*32 +: 32] = pm[k];
        check("R4 R3 result memory", got, exp_res);
        if (busy_pulse) begin
            repeat (3) @(negedge clk);
            check("R7 no restart after busy pulse", 256'(rdy), 256'(1));
        end
    endtask

    initial begin
        rst_n = 1'b0;
        ena   = 1'b0;
        for (int k = 0; k < 8; k++) begin
            xm[k] = '0; ym[k] = '0; nm[k] = '0; pm[k] = '0;
        end
        repeat (3) @(negedge clk);
        check("R1 rdy in reset", 256'(rdy), 256'(1));
        check("R1 no write in reset", 256'(p_wren), 256'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdy after reset", 256'(rdy), 256'(1));
        check("R1 no write after reset", 256'(p_wren), 256'(0));

        run_op(PRIME - 1, PRIME - 1, 1'b0);
        run_op(256'd1, rnd_reduced(), 1'b0);
        run_op(256'd0, rnd_reduced(), 1'b0);
        run_op(PRIME - 1, 256'd2, 1'b0);
        run_op(rnd_reduced(), rnd_reduced(), 1'b1);
        for (int i = 0; i < 8; i++) run_op(rnd_reduced(), rnd_reduced(), 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule